// File: doc/BRIEF.md
# PCI Master Termination and Reissue Sequencer

This block sits inside a PCI bus master, between an internal request source and the logic that drives the PCI bus. It accepts one transfer at a time as a start address, a word count and a direction. It starts the bus access, then waits for the report of how the target ended that access. The block tracks the address of the current access and the number of words still to move. When the target stops the access early it starts the access again, either for the same words or for the words not yet moved. An abort, or a run of retries with no progress, ends the transfer with an error.

The controller has five states. `S_IDLE` waits for a request; the *accept* transition moves to `S_ISSUE`. `S_ISSUE` pulses the access start for one cycle and always moves to `S_ACTIVE`. In `S_ACTIVE` a termination report takes one of these transitions: *finish* to `S_RESP` when every word has moved, *resume* to `S_HOLD` after a disconnect or a short completion, *repeat* to `S_HOLD` after a retry that is within the limit, *expire* to `S_RESP` after a retry that is over the limit, and *abandon* to `S_RESP` on either abort. `S_HOLD` keeps the bus request down for a fixed number of cycles and then takes *reissue* back to `S_ISSUE`. `S_RESP` holds the response for one cycle and then takes *release* to `S_IDLE`.

Arbitration and the PCI pin protocol are handled elsewhere. The termination report arrives already decoded as a kind and a count of completed data phases.

Top module: `pci_reissue_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request taken there produces a single-cycle `bus_start` in the next cycle, with `bus_addr`, `bus_words` and `bus_write` equal to the request fields.
- R2: A termination with `term_kind`=1 (disconnect) and `term_phases` below the current word count reissues the access at address plus 4×phases, with the word count reduced by phases.
- R3: A termination with `term_kind`=2 (retry) that is within the limit reissues the same address, word count and direction that were last issued.
- R4: After a reissuing termination, `bus_start` stays low for exactly `HOLD_CYCLES` cycles (default 2) before it pulses again.
- R5: A retry that arrives when the count of consecutive retries already equals `retry_limit` ends the transfer with `resp_status`=3 (timeout). Any disconnect or completion clears that count.
- R6: `term_kind`=3 (master abort) ends the transfer in the next cycle with `resp_status`=1.
- R7: `term_kind`=4 (target abort) ends the transfer in the next cycle with `resp_status`=2.
- R8: `resp_status`=0 (done) is given only when the remaining count reaches zero, through `term_kind`=0 (completion) or a disconnect whose phases cover every remaining word. A completion with fewer phases reissues the remainder in the same way as R2.
- R9: `resp_valid` lasts one cycle and carries `resp_write` equal to the request direction. In the next cycle `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New transfer request |
| req_addr | input | ADDR_W | Start byte address |
| req_words | input | CNT_W | Number of words, nonzero |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Ready to take a request |
| retry_limit | input | RTRY_W | Number of consecutive retries allowed |
| bus_start | output | 1 | One-cycle pulse that starts a bus access |
| bus_addr | output | ADDR_W | Address of the access |
| bus_words | output | CNT_W | Words in the access |
| bus_write | output | 1 | Direction of the access |
| term_valid | input | 1 | Termination report is present |
| term_kind | input | 3 | 0 complete, 1 disconnect, 2 retry, 3 master abort, 4 target abort |
| term_phases | input | CNT_W | Data phases completed before termination |
| resp_valid | output | 1 | Transfer finished |
| resp_status | output | 2 | 0 done, 1 master abort, 2 target abort, 3 retry timeout |
| resp_write | output | 1 | Direction of the finished transfer |

## Verification
The assertions assume that `term_valid` is raised only while an access is in flight, that is, after `bus_start` and before the next response or reissue. They also assume that `retry_limit` stays fixed for the duration of a transfer and that `req_words` is never zero. The bench follows all three rules. It sends exactly one termination report for each observed `bus_start`, and it changes the limit only while the block is idle. Every request it sends has at least one word.

// File: rtl/pci_rs_pkg.sv
package pci_rs_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ISSUE  = 3'd1,
        S_ACTIVE = 3'd2,
        S_HOLD   = 3'd3,
        S_RESP   = 3'd4
    } seq_state_t;

    typedef enum logic [2:0] {
        TK_CMPL  = 3'd0,
        TK_DISC  = 3'd1,
        TK_RETRY = 3'd2,
        TK_MABT  = 3'd3,
        TK_TABT  = 3'd4
    } term_kind_t;

    typedef enum logic [1:0] {
        RS_DONE    = 2'd0,
        RS_MABT    = 2'd1,
        RS_TABT    = 2'd2,
        RS_TIMEOUT = 2'd3
    } resp_status_t;

endpackage

// File: rtl/pci_rs_xfer_track.sv
module pci_rs_xfer_track #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_words,
    input  logic              ld_write,
    input  logic              advance,
    input  logic [CNT_W-1:0]  phases,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_words,
    output logic              cur_write,
    output logic              all_moved
);
    localparam int PAD_W = ADDR_W - CNT_W - 2;

    logic [ADDR_W-1:0] byte_step;

    assign byte_step = {{PAD_W{1'b0}}, phases, 2'b00};
    assign all_moved = (phases >= cur_words);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_words <= '0;
            cur_write <= 1'b0;
        end else if (load) begin
            cur_addr  <= ld_addr;
            cur_words <= ld_words;
            cur_write <= ld_write;
        end else if (advance) begin
            cur_addr  <= cur_addr + byte_step;
            cur_words <= all_moved ? '0 : (cur_words - phases);
        end
    end

    // progress never grows the outstanding count
    assert_words_shrink_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (cur_words <= $past(cur_words)));

    // direction is fixed for the life of a transfer
    assert_dir_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cur_write));

endmodule

// File: rtl/pci_rs_retry_ctr.sv
module pci_rs_retry_ctr #(
    parameter int RTRY_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bump,
    input  logic [RTRY_W-1:0] limit,
    output logic              exhausted
);
    logic [RTRY_W-1:0] cnt;

    assign exhausted = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (bump) begin
            cnt <= cnt + 1'b1;
        end
    end

    // the controller only counts a retry that is still within the limit
    assert_bump_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> (cnt < limit));

endmodule

// File: rtl/pci_rs_holdoff.sv
module pci_rs_holdoff #(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int HW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYCLES - 1);

    logic [HW-1:0] cnt;

    assign expired = active && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // the controller stays in the wait until the count runs out
    assert_hold_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !expired) |=> active);

endmodule

// File: rtl/pci_reissue_seq.sv
module pci_reissue_seq #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 8,
    parameter int RTRY_W      = 4,
    parameter int HOLD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_words,
    input  logic              req_write,
    output logic              req_ready,
    input  logic [RTRY_W-1:0] retry_limit,
    output logic              bus_start,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [CNT_W-1:0]  bus_words,
    output logic              bus_write,
    input  logic              term_valid,
    input  logic [2:0]        term_kind,
    input  logic [CNT_W-1:0]  term_phases,
    output logic              resp_valid,
    output logic [1:0]        resp_status,
    output logic              resp_write
);
    import pci_rs_pkg::*;

    seq_state_t   state, state_nx;
    resp_status_t status_q, status_nx;

    logic term_in, load, adv, bump, clr;
    logic all_moved, exhausted, hold_done;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_words;
    logic              cur_write;

    assign term_in = (state == S_ACTIVE) && term_valid;
    assign load    = (state == S_IDLE) && req_valid;
    assign adv     = term_in && ((term_kind == TK_CMPL) || (term_kind == TK_DISC));
    assign bump    = term_in && (term_kind == TK_RETRY) && !exhausted;
    assign clr     = load || adv;

    pci_rs_xfer_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_addr   (req_addr),
        .ld_words  (req_words),
        .ld_write  (req_write),
        .advance   (adv),
        .phases    (term_phases),
        .cur_addr  (cur_addr),
        .cur_words (cur_words),
        .cur_write (cur_write),
        .all_moved (all_moved)
    );

    pci_rs_retry_ctr #(.RTRY_W(RTRY_W)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .bump      (bump),
        .limit     (retry_limit),
        .exhausted (exhausted)
    );

    pci_rs_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state == S_HOLD),
        .expired (hold_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            status_q <= RS_DONE;
        end else begin
            state    <= state_nx;
            status_q <= status_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx  = state;
        status_nx = status_q;
        unique case (state)
            S_IDLE: begin
                if (req_valid) state_nx = S_ISSUE;          // accept
            end
            S_ISSUE: begin
                state_nx = S_ACTIVE;
            end
            S_ACTIVE: begin
                if (term_valid) begin
                    case (term_kind)
                        TK_CMPL, TK_DISC: begin
                            if (all_moved) begin             // finish
                                state_nx  = S_RESP;
                                status_nx = RS_DONE;
                            end else begin                   // resume
                                state_nx = S_HOLD;
                            end
                        end
                        TK_RETRY: begin
                            if (exhausted) begin             // expire
                                state_nx  = S_RESP;
                                status_nx = RS_TIMEOUT;
                            end else begin                   // repeat
                                state_nx = S_HOLD;
                            end
                        end
                        TK_MABT: begin                       // abandon
                            state_nx  = S_RESP;
                            status_nx = RS_MABT;
                        end
                        TK_TABT: begin                       // abandon
                            state_nx  = S_RESP;
                            status_nx = RS_TABT;
                        end
                        default: state_nx = S_ACTIVE;
                    endcase
                end
            end
            S_HOLD: begin
                if (hold_done) state_nx = S_ISSUE;          // reissue
            end
            S_RESP: begin
                state_nx = S_IDLE;                          // release
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = (state == S_IDLE);
        bus_start   = (state == S_ISSUE);
        resp_valid  = (state == S_RESP);
        bus_addr    = cur_addr;
        bus_words   = cur_words;
        bus_write   = cur_write;
        resp_status = status_q;
        resp_write  = cur_write;
    end

    assert_issue_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start);

    assert_accept_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (bus_start && bus_addr == $past(req_addr)
                                      && bus_words == $past(req_words)));

    assert_retry_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> ($stable(bus_addr) && $stable(bus_words)));

    assert_hold_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (term_in && (term_kind == TK_RETRY) && !exhausted) |=> !bus_start ##1 !bus_start);

    assert_timeout_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) && (resp_status == RS_TIMEOUT) |-> $past(term_kind == TK_RETRY));

    assert_mabt_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (term_in && term_kind == TK_MABT) |=> (resp_valid && resp_status == RS_MABT));

    assert_tabt_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (term_in && term_kind == TK_TABT) |=> (resp_valid && resp_status == RS_TABT));

    assert_no_early_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (term_in && (term_kind == TK_DISC) && (term_phases < bus_words)) |=> !resp_valid);

    assert_resp_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (req_ready && !resp_valid));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, bus_start, resp_valid}));

endmodule

// File: tb/pci_reissue_seq_bench.sv
module pci_reissue_seq_bench;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int RW = 4;
    localparam int HOLD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_words = '0;
    logic          req_write = 1'b0;
    logic          req_ready;
    logic [RW-1:0] retry_limit = '0;
    logic          bus_start;
    logic [AW-1:0] bus_addr;
    logic [CW-1:0] bus_words;
    logic          bus_write;
    logic          term_valid = 1'b0;
    logic [2:0]    term_kind = '0;
    logic [CW-1:0] term_phases = '0;
    logic          resp_valid;
    logic [1:0]    resp_status;
    logic          resp_write;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pci_reissue_seq #(.ADDR_W(AW), .CNT_W(CW), .RTRY_W(RW), .HOLD_CYCLES(HOLD)) u_pci_reissue_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_words(req_words),
        .req_write(req_write), .req_ready(req_ready), .retry_limit(retry_limit),
        .bus_start(bus_start), .bus_addr(bus_addr), .bus_words(bus_words),
        .bus_write(bus_write), .term_valid(term_valid), .term_kind(term_kind),
        .term_phases(term_phases), .resp_valid(resp_valid),
        .resp_status(resp_status), .resp_write(resp_write)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic request(input logic [AW-1:0] a, input int w, input bit wr);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_words = CW'(w); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // waits for the start pulse, checks the gap and the access fields
    task automatic expect_issue(input logic [AW-1:0] a, input int w, input bit wr,
                                input int gap, input string tag);
        int n = 0;
        while (!bus_start && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(n == gap, {tag, " R4 gap"}, n, gap);
        chk(bus_addr == a, {tag, " addr"}, bus_addr, a);
        chk(bus_words == CW'(w), {tag, " words"}, bus_words, w);
        chk(bus_write == wr, {tag, " R1 dir"}, bus_write, wr);
    endtask

    task automatic terminate(input int kind, input int ph);
        @(negedge clk);
        term_valid = 1'b1; term_kind = 3'(kind); term_phases = CW'(ph);
        @(negedge clk);
        term_valid = 1'b0;
    endtask

    task automatic expect_resp(input int st, input bit wr, input string tag);
        chk(resp_valid == 1'b1, {tag, " resp_valid"}, resp_valid, 1);
        chk(resp_status == 2'(st), {tag, " status"}, resp_status, st);
        chk(resp_write == wr, {tag, " R9 resp_write"}, resp_write, wr);
        @(negedge clk);
        chk(req_ready && !resp_valid, "R9 release to idle", req_ready, 1);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        chk(bus_start == 1'b0, "R1 reset start", bus_start, 0);
        chk(resp_valid == 1'b0, "R9 reset resp", resp_valid, 0);

        // R2, R8: every disconnect split of 1..5 words
        for (int w = 1; w <= 5; w++) begin
            for (int p = 0; p < w; p++) begin
                logic [AW-1:0] a = 32'h1000_0000 + AW'(w * 256 + p * 16);
                bit wr = (w + p) % 2;
                request(a, w, wr);
                expect_issue(a, w, wr, 0, "R1 first issue");
                terminate(1, p);
                chk(resp_valid == 1'b0, "R8 no done after partial disconnect", resp_valid, 0);
                expect_issue(a + AW'(4 * p), w - p, wr, HOLD, "R2 resume");
                terminate(0, w - p);
                expect_resp(0, wr, "R8 done");
            end
        end

        // R8: short completion resumes the remainder; full disconnect finishes
        request(32'h2000, 4, 1'b0);
        expect_issue(32'h2000, 4, 1'b0, 0, "R1 issue");
        terminate(0, 1);
        chk(resp_valid == 1'b0, "R8 short completion not done", resp_valid, 0);
        expect_issue(32'h2004, 3, 1'b0, HOLD, "R8 remainder");
        terminate(1, 3);
        expect_resp(0, 1'b0, "R8 disconnect covering all");

        // R3, R5: limits 0..3, retries up to the limit then one more
        for (int lim = 0; lim <= 3; lim++) begin
            logic [AW-1:0] a = 32'h3000 + AW'(lim * 64);
            retry_limit = RW'(lim);
            request(a, 3, 1'b1);
            expect_issue(a, 3, 1'b1, 0, "R1 issue");
            for (int k = 0; k < lim; k++) begin
                terminate(2, 0);
                chk(resp_valid == 1'b0, "R3 retry within limit", resp_valid, 0);
                expect_issue(a, 3, 1'b1, HOLD, "R3 reissue same");
            end
            terminate(2, 0);
            expect_resp(3, 1'b1, "R5 timeout");
        end

        // R5: progress clears the retry count; R3 retry after disconnect
        retry_limit = RW'(1);
        request(32'h4000, 4, 1'b0);
        expect_issue(32'h4000, 4, 1'b0, 0, "R1 issue");
        terminate(2, 0);
        expect_issue(32'h4000, 4, 1'b0, HOLD, "R3 reissue");
        terminate(1, 2);
        expect_issue(32'h4008, 2, 1'b0, HOLD, "R2 resume");
        terminate(2, 0);
        chk(resp_valid == 1'b0, "R5 count cleared by progress", resp_valid, 0);
        expect_issue(32'h4008, 2, 1'b0, HOLD, "R3 reissue reduced access");
        terminate(0, 2);
        expect_resp(0, 1'b0, "R8 done after mixed");

        // R6, R7: both aborts, both directions, with and without prior progress
        for (int kind = 3; kind <= 4; kind++) begin
            for (int wr = 0; wr <= 1; wr++) begin
                for (int pre = 0; pre <= 1; pre++) begin
                    logic [AW-1:0] a = 32'h5000 + AW'(kind * 256 + wr * 32 + pre * 8);
                    request(a, 5, wr[0]);
                    expect_issue(a, 5, wr[0], 0, "R1 issue");
                    if (pre == 1) begin
                        terminate(1, 1);
                        expect_issue(a + 4, 4, wr[0], HOLD, "R2 resume");
                    end
                    terminate(kind, 0);
                    expect_resp(kind - 2, wr[0], kind == 3 ? "R6 master abort" : "R7 target abort");
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule